// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block turns single bus phases into SCL and SDA edges for an I2C master. A command sequencer asks for one phase at a time: a START, a data bit, an acknowledge bit, a repeated START or a STOP. The block finishes the phase from cycle counts held in a timing word and answers with a one-cycle done pulse. For bit phases it also returns the SDA level sampled at the end of the SCL high period.

Every count is in units of 2^prescale clock cycles. A timing word holds four counts: SCL low, SCL high, setup/hold and data-valid delay. Two timing words are supplied, one for normal modes and one for high-speed mode, and a select input picks the one latched when a phase is accepted. The sampled SCL and SDA inputs each pass through their own programmable glitch filter. The SCL high count starts only once the filtered SCL is seen high, so a target that holds SCL low stretches the clock. A mode input chooses open-drain or push-pull drive.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset scl_out and sda_out are 1, done and busy are 0, and in open-drain mode scl_oe and sda_oe are 0.
- R2: A timing word holds the SCL-low count in bits 5:0 (bits 7:6 are ignored), the SCL-high count in 15:8, the setup/hold count in 23:16 and the data-valid delay in 31:24. The word is timing_hs when hs_sel is 1 at acceptance, otherwise timing_norm.
- R3: One count unit lasts 2^prescale clock cycles. A segment of count n lasts max(n·2^prescale, 1) cycles.
- R4: START (phase code 0) pulls sda_out low in the accept cycle. scl_out falls one setup/hold segment later, in the same cycle as done.
- R5: In a data bit (code 1) or acknowledge bit (code 2), scl_out stays low for one SCL-low segment from acceptance. sda_out takes the bit after min(delay, low)·2^prescale cycles and holds it while SCL is high.
- R6: In open-drain mode the SCL high count starts the cycle after the filtered SCL is seen high. The high period of scl_out is therefore max(S,1) + F + max(high·2^prescale,1) cycles, where S is the cycles the line is held low after release and F is the SCL filter length.
- R7: At the end of a bit phase, rx_bit holds the filtered SDA level at that moment.
- R8: Repeated START (code 3) releases SDA, holds SCL low for one low segment and releases SCL. After the high wait and one setup/hold segment it pulls SDA low, and it pulls SCL low one setup/hold segment after that.
- R9: STOP (code 4) pulls SDA low, holds SCL low for one low segment and releases SCL. After the high wait and one setup/hold segment it releases SDA.
- R10: A filter of length N (SDA in filt_cfg bits 27:24, SCL in bits 19:16) passes a new level only after it has been stable for N prescaled ticks. A shorter pulse is dropped. N=0 passes the input straight through.
- R11: With push_pull=0 an output enable is 1 only while its line is driven low. With push_pull=1 both enables are 1, the SCL high count starts one cycle after release, and stretching is ignored.
- R12: A request is taken only while busy is 0. busy lasts from acceptance until done. done is a one-cycle pulse. req_bit changes after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_norm | input | 32 | Timing word for normal modes |
| timing_hs | input | 32 | Timing word for high-speed mode |
| hs_sel | input | 1 | Selects the high-speed timing word |
| prescale | input | 3 | Count unit is 2^prescale cycles |
| filt_cfg | input | 32 | Filter lengths, SDA 27:24, SCL 19:16 |
| push_pull | input | 1 | 1 = push-pull drive, 0 = open-drain |
| req | input | 1 | Phase request |
| req_phase | input | 3 | 0 START, 1 data, 2 ack, 3 repeated START, 4 STOP |
| req_bit | input | 1 | Bit to send (1 releases SDA for reading) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A phase is in progress |
| rx_bit | output | 1 | SDA sampled at the end of the last bit phase |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_out | output | 1 | Wanted SCL level |
| scl_oe | output | 1 | SCL output enable |
| sda_out | output | 1 | Wanted SDA level |
| sda_oe | output | 1 | SDA output enable |

## Verification
A wrong count or an off-by-one segment end moves an SCL or SDA edge. That shows within one phase as a low, high, setup or data-valid period that differs from the computed cycle count. A filter that passes glitches, or a high count that does not wait for the filtered SCL, shortens the high period of the stretched bit in which it occurs. A wrong state transition or timing-word selection either hangs the handshake or moves every edge of the next phase, and the check made at that phase's done pulse reports it.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  localparam int PRE_W = 3;
  localparam int FLT_W = 4;
  localparam int CNT_W = 8 + (1 << PRE_W);

  typedef enum logic [2:0] {
    PH_START  = 3'd0,
    PH_DATA   = 3'd1,
    PH_ACK    = 3'd2,
    PH_RSTART = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [7:0] dv;
    logic [7:0] sh;
    logic [7:0] hi;
    logic [5:0] lo;
  } timing_t;

  function automatic timing_t unpack_timing(input logic [31:0] w);
    timing_t t;
    t.dv = w[31:24];
    t.sh = w[23:16];
    t.hi = w[15:8];
    t.lo = w[5:0];
    return t;
  endfunction

  // count units -> clock cycles
  function automatic logic [CNT_W-1:0] scale_units(input logic [7:0] n,
                                                   input logic [PRE_W-1:0] p);
    return {{(CNT_W-8){1'b0}}, n} << p;
  endfunction

  function automatic logic [7:0] dv_clamp(input logic [7:0] dv, input logic [5:0] lo);
    return (dv > {2'b00, lo}) ? {2'b00, lo} : dv;
  endfunction

  // segment ends on the cycle whose count reaches the target (target 0 acts as 1)
  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] tgt);
    return (cnt + 1'b1) >= tgt;
  endfunction
endpackage

// File: rtl/i2c_bt_prescale.sv
module i2c_bt_prescale #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  output logic          tick
);
  localparam int DW = (1 << PW) - 1;
  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;

  assign mask = ~({DW{1'b1}} << prescale);
  assign tick = ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/i2c_bt_filter.sv
module i2c_bt_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [FW-1:0] len,
  input  logic          raw,
  output logic          filt
);
  logic          lvl_q;
  logic [FW-1:0] run_q;

  assign filt = (len == '0) ? raw : lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (len == '0) begin
      lvl_q <= raw;
      run_q <= '0;
    end else if (raw == lvl_q) begin
      run_q <= '0;
    end else if (tick) begin
      if (run_q == len - 1'b1) begin
        lvl_q <= raw;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bt_engine.sv
module i2c_bt_engine
  import i2c_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  timing_t          tim_sel,
  input  logic [PRE_W-1:0] prescale,
  input  logic             push_pull,
  input  logic             req,
  input  logic [2:0]       req_phase,
  input  logic             req_bit,
  input  logic             scl_f,
  input  logic             sda_f,
  output logic             done,
  output logic             busy,
  output logic             rx_bit,
  output logic             scl_q,
  output logic             sda_q,
  output logic             hi_run,
  output logic             data_high
);
  typedef enum logic [2:0] {
    S_IDLE, S_ST_HOLD, S_LOW, S_HI_WAIT, S_HIGH, S_SETUP, S_RS_HOLD
  } st_e;

  st_e              st;
  logic [CNT_W-1:0] cnt;
  phase_e           ph;
  logic             bit_l;
  timing_t          tl;

  logic [CNT_W-1:0] lot, hit, sht, dvt, dvt_acc;
  logic             is_data;

  assign lot     = scale_units({2'b00, tl.lo}, prescale);
  assign hit     = scale_units(tl.hi, prescale);
  assign sht     = scale_units(tl.sh, prescale);
  assign dvt     = scale_units(dv_clamp(tl.dv, tl.lo), prescale);
  assign dvt_acc = scale_units(dv_clamp(tim_sel.dv, tim_sel.lo), prescale);
  assign is_data = (ph == PH_DATA) || (ph == PH_ACK);

  assign busy      = (st != S_IDLE);
  assign hi_run    = (st == S_HIGH);
  assign data_high = busy && is_data && scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= PH_START;
      bit_l  <= 1'b1;
      tl     <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      done   <= 1'b0;
      rx_bit <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          cnt   <= '0;
          bit_l <= req_bit;
          tl    <= tim_sel;
          ph    <= phase_e'(req_phase);
          case (req_phase)
            PH_START: begin
              sda_q <= 1'b0;
              st    <= S_ST_HOLD;
            end
            PH_DATA, PH_ACK: begin
              if (dvt_acc == '0) sda_q <= req_bit;
              st <= S_LOW;
            end
            PH_RSTART: begin
              sda_q <= 1'b1;
              st    <= S_LOW;
            end
            PH_STOP: begin
              sda_q <= 1'b0;
              st    <= S_LOW;
            end
            default: done <= 1'b1;
          endcase
        end
        S_ST_HOLD: begin
          if (reached(cnt, sht)) begin
            scl_q <= 1'b0;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (is_data && reached(cnt, dvt)) sda_q <= bit_l;
          if (reached(cnt, lot)) begin
            if (is_data) sda_q <= bit_l;
            scl_q <= 1'b1;
            cnt   <= '0;
            st    <= S_HI_WAIT;
          end else cnt <= cnt + 1'b1;
        end
        S_HI_WAIT: if (push_pull || scl_f) begin
          cnt <= '0;
          st  <= is_data ? S_HIGH : S_SETUP;
        end
        S_HIGH: begin
          if (reached(cnt, hit)) begin
            rx_bit <= sda_f;
            scl_q  <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_SETUP: begin
          if (reached(cnt, sht)) begin
            cnt <= '0;
            if (ph == PH_STOP) begin
              sda_q <= 1'b1;
              done  <= 1'b1;
              st    <= S_IDLE;
            end else begin
              sda_q <= 1'b0;
              st    <= S_RS_HOLD;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RS_HOLD: begin
          if (reached(cnt, sht)) begin
            scl_q <= 1'b0;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] timing_norm,
  input  logic [31:0] timing_hs,
  input  logic        hs_sel,
  input  logic [2:0]  prescale,
  input  logic [31:0] filt_cfg,
  input  logic        push_pull,
  input  logic        req,
  input  logic [2:0]  req_phase,
  input  logic        req_bit,
  output logic        done,
  output logic        busy,
  output logic        rx_bit,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_out,
  output logic        scl_oe,
  output logic        sda_out,
  output logic        sda_oe
);
  logic             tick;
  timing_t          tim_sel;
  logic [1:0]       raw_v, filt_v;
  logic [FLT_W-1:0] len_v [2];
  logic             scl_filt, sda_filt;
  logic             hi_count_run, data_scl_high;

  assign tim_sel = hs_sel ? unpack_timing(timing_hs) : unpack_timing(timing_norm);

  i2c_bt_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .tick(tick)
  );

  // index 0: SCL, index 1: SDA
  assign raw_v    = {sda_in, scl_in};
  assign len_v[0] = filt_cfg[19:16];
  assign len_v[1] = filt_cfg[27:24];

  for (genvar gi = 0; gi < 2; gi++) begin : g_filt
    i2c_bt_filter #(.FW(FLT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .len(len_v[gi]),
      .raw(raw_v[gi]), .filt(filt_v[gi])
    );
  end

  assign scl_filt = filt_v[0];
  assign sda_filt = filt_v[1];

  i2c_bt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tim_sel(tim_sel), .prescale(prescale),
    .push_pull(push_pull), .req(req), .req_phase(req_phase), .req_bit(req_bit),
    .scl_f(scl_filt), .sda_f(sda_filt), .done(done), .busy(busy),
    .rx_bit(rx_bit), .scl_q(scl_out), .sda_q(sda_out),
    .hi_run(hi_count_run), .data_high(data_scl_high)
  );

  assign scl_oe = push_pull | ~scl_out;
  assign sda_oe = push_pull | ~sda_out;
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic [2:0] req_phase,
  input logic       done,
  input logic       busy,
  input logic       push_pull,
  input logic       scl_out,
  input logic       scl_oe,
  input logic       sda_out,
  input logic       sda_oe,
  input logic       scl_filt,
  input logic       hi_count_run,
  input logic       data_scl_high
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R12
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && (req_phase <= 3'd4)) |=> busy);

  // R6
  stretch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_count_run) |-> $past(scl_filt || push_pull));

  // R11
  od_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull |-> (!(scl_oe && scl_out) && !(sda_oe && sda_out)));

  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_scl_high && $past(data_scl_high)) |-> $stable(sda_out));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_phase(req_phase), .done(done),
  .busy(busy), .push_pull(push_pull), .scl_out(scl_out), .scl_oe(scl_oe),
  .sda_out(sda_out), .sda_oe(sda_oe), .scl_filt(scl_filt),
  .hi_count_run(hi_count_run), .data_scl_high(data_scl_high)
);

// File: tb/i2c_bit_timer_tb.sv
module i2c_bit_timer_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] timing_norm = '0, timing_hs = '0, filt_cfg = '0;
  logic        hs_sel = 1'b0, push_pull = 1'b0, req = 1'b0, req_bit = 1'b0;
  logic [2:0]  prescale = '0, req_phase = '0;
  logic        done, busy, rx_bit, scl_out, scl_oe, sda_out, sda_oe;
  logic        scl_in, sda_in, hold, tgt_low = 1'b0;
  int          stretch_left = 0, glitch_at = -1;
  int          total = 0, bad = 0;

  always_comb hold = (stretch_left > 0) && (stretch_left != glitch_at);
  assign scl_in = scl_out & ~hold;
  assign sda_in = sda_out & ~tgt_low;

  i2c_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .timing_norm(timing_norm), .timing_hs(timing_hs),
    .hs_sel(hs_sel), .prescale(prescale), .filt_cfg(filt_cfg),
    .push_pull(push_pull), .req(req), .req_phase(req_phase), .req_bit(req_bit),
    .done(done), .busy(busy), .rx_bit(rx_bit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_out(scl_out), .scl_oe(scl_oe), .sda_out(sda_out), .sda_oe(sda_oe)
  );

  typedef struct {
    int    lo; int dv; int h1; int h0; int rx; string nm;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(string rq, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // target model: holds SCL low for a number of cycles after release
  always @(negedge clk)
    if (scl_out && busy && stretch_left > 0) stretch_left--;

  // monitor
  int   m_lo = 0, m_dv = 0, m_h1 = 0, m_h0 = 0;
  logic cur_bit = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!scl_out) begin
          m_lo++;
          if (sda_out != cur_bit) m_dv++;
        end else if (sda_out) m_h1++;
        else m_h0++;
      end
      if (done) begin
        exp_t e;
        // R12 done is a single-cycle pulse and busy has ended
        chk("R12 done/busy", {prev_done, busy}, 0);
        if (exp_q.size() == 0) chk("R12 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk({e.nm, " low"}, m_lo, e.lo);
          if (e.dv >= 0) chk({e.nm, " data-valid"}, m_dv, e.dv);
          chk({e.nm, " high sda1"}, m_h1, e.h1);
          chk({e.nm, " high sda0"}, m_h0, e.h0);
          if (e.rx >= 0) chk({e.nm, " rx_bit"}, int'(rx_bit), e.rx);
        end
        m_lo = 0; m_dv = 0; m_h1 = 0; m_h0 = 0;
      end
      prev_done = done;
    end
  end

  function automatic int seg(int n);
    int c = n << prescale;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic run(int ph, bit b, bit tl, int s, int g, bit flip, string nm);
    exp_t e;
    logic [31:0] w = hs_sel ? timing_hs : timing_norm;
    int lo = int'(w & 32'h3f), hi = int'((w >> 8) & 32'hff);
    int sh = int'((w >> 16) & 32'hff), dv = int'((w >> 24) & 32'hff);
    int nf = int'((filt_cfg >> 16) & 32'hf);
    int wt = push_pull ? 1 : ((s > 1 ? s : 1) + nf);
    e.nm = nm; e.lo = 0; e.dv = -1; e.h1 = 0; e.h0 = 0; e.rx = -1;
    @(negedge clk);
    case (ph)
      0: e.h0 = seg(sh);
      1, 2: begin
        e.lo = seg(lo);
        e.dv = (sda_out != b) ? ((dv < lo ? dv : lo) << prescale) : 0;
        if (b) e.h1 = wt + seg(hi); else e.h0 = wt + seg(hi);
        e.rx = int'(b & ~tl);
      end
      3: begin e.lo = seg(lo); e.h1 = wt + seg(sh); e.h0 = seg(sh); end
      default: begin e.lo = seg(lo); e.h0 = wt + seg(sh); end
    endcase
    exp_q.push_back(e);
    cur_bit = b; req_phase = 3'(ph); req_bit = b; tgt_low = tl;
    stretch_left = s; glitch_at = g; req = 1'b1;
    @(negedge clk);
    if (flip) req_bit = ~b;
    while (!done) @(negedge clk);
    req = 1'b0; tgt_low = 1'b0; stretch_left = 0; glitch_at = -1;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    timing_norm = {8'd2, 8'd3, 8'd4, 8'd6};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_out", int'(scl_out), 1);
    chk("R1 sda_out", int'(sda_out), 1);
    chk("R1 done/busy", int'({done, busy}), 0);
    chk("R1 oe", int'({scl_oe, sda_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R7 R8 R9 basic sequence
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R4 start");
    run(1, 1'b1, 1'b0, 0, -1, 1'b0, "R5 data1");
    run(1, 1'b0, 1'b0, 0, -1, 1'b0, "R5 data0");
    run(2, 1'b1, 1'b1, 0, -1, 1'b0, "R7 ack read");
    run(1, 1'b1, 1'b0, 5, -1, 1'b0, "R6 stretch");
    run(3, 1'b0, 1'b0, 0, -1, 1'b0, "R8 rstart");
    run(1, 1'b0, 1'b0, 0, -1, 1'b0, "R5 after rstart");
    // R12 req_bit flipped mid-phase has no effect
    run(1, 1'b1, 1'b0, 0, -1, 1'b1, "R12 flip");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R9 stop");

    // R5 data-valid delay clamped to low count, and zero delay
    timing_norm = {8'd9, 8'd2, 8'd3, 8'd5};
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R4 start2");
    run(1, 1'b1, 1'b0, 0, -1, 1'b0, "R5 dv clamp");
    timing_norm = {8'd0, 8'd2, 8'd3, 8'd5};
    run(1, 1'b0, 1'b0, 0, -1, 1'b0, "R5 dv zero");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R9 stop2");

    // R3 prescale by 2
    prescale = 3'd1;
    timing_norm = {8'd1, 8'd2, 8'd2, 8'd3};
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R3 start");
    run(1, 1'b1, 1'b0, 0, -1, 1'b0, "R3 data");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R3 stop");
    prescale = 3'd0;

    // R2 high-speed word, low byte bits 7:6 set and ignored
    hs_sel = 1'b1;
    timing_hs = {8'd3, 8'd1, 8'd7, 8'hC4};
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R2 hs start");
    run(1, 1'b1, 1'b0, 0, -1, 1'b0, "R2 hs data");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R2 hs stop");
    hs_sel = 1'b0;

    // R10 filters: SCL glitch during stretch dropped, SDA filtered read
    timing_norm = {8'd2, 8'd3, 8'd4, 8'd8};
    filt_cfg = 32'h0202_0000;
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R10 start");
    run(1, 1'b1, 1'b0, 6, 3, 1'b0, "R10 glitch");
    run(2, 1'b1, 1'b1, 0, -1, 1'b0, "R10 sda read");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R10 stop");
    filt_cfg = '0;

    // R11 push-pull: enables high, stretch ignored
    push_pull = 1'b1;
    @(negedge clk);
    chk("R11 pp oe", int'({scl_oe, sda_oe}), 3);
    run(0, 1'b0, 1'b0, 0, -1, 1'b0, "R11 start");
    run(1, 1'b1, 1'b0, 5, -1, 1'b0, "R11 no stretch");
    run(4, 1'b0, 1'b0, 0, -1, 1'b0, "R11 stop");
    push_pull = 1'b0;
    @(negedge clk);
    chk("R11 od oe", int'({scl_oe, sda_oe}), 0);

    repeat (3) @(negedge clk);
    chk("R12 queue empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule